// File: doc/BRIEF.md
# Multi-Group ADC Conversion Sequencer

This block drives a successive-approximation converter from a small bank of channel-group control slots. Each slot stores a 5-bit channel number and an interrupt enable, and keeps its own done flag and result register. At any moment at most one slot owns the converter. The sequencer runs a sample phase, timed in divided converter clocks, and then pulses a start strobe with the slot's channel. It waits for the converter to return a sample, stores that sample in the owning slot and raises the slot's done flag.

Two trigger modes exist. In software mode only slot 0 starts conversions, and it does so when it is written. In hardware mode every trigger pulse that arrives while the sequencer is idle hands the converter to the next slot in round-robin order. A continuous setting re-arms the same slot after each completion. Writing the slot that currently owns the converter aborts the conversion in progress.

Top module: `adc_grp_seq`

## Requirements
- R1: In software mode (hw_mode_i=0), a write to slot 0 while idle starts a conversion of that slot, and conv_chan_o carries the channel just written when conv_start_o pulses.
- R2: In software mode, a write to any slot other than 0 never starts a conversion: active_o stays low.
- R3: The sample phase lasts L converter clocks. L is 24, 16, 10 or 6 for long_mode_i = 0, 1, 2 or 3, and 4 for any other value. One converter clock is 2^clk_div_i input clocks. conv_start_o is a single-cycle pulse that first appears L*2^clk_div_i input clocks after the starting edge.
- R4: When conv_done_i arrives during conversion, conv_data_i is stored in the owning slot's result and that slot's done_o bit is set. No other slot's bit changes.
- R5: irq_o is high exactly when some slot has both its done bit and its interrupt enable set.
- R6: rd_data_o shows the result of slot rd_grp_i. A cycle with rd_en_i high clears that slot's done bit.
- R7: In hardware mode, a hw_trig_i pulse while idle starts slot 0, then 1, 2 and so on, wrapping after the last slot. A trigger while active is ignored and does not advance the order.
- R8: A write to the active slot aborts the conversion. conv_abort_o pulses if the converter had been started, no done bit is set and the old result is kept. In software mode, a write to an active slot 0 restarts its sample phase.
- R9: Writing a slot that is not active while a conversion runs leaves that conversion untouched, including its channel.
- R10: active_o is high from the starting edge until completion or abort, and conv_start_o only occurs while active_o is high.
- R11: With cont_i high, a completing slot starts a new sample phase at once. Clearing cont_i lets the next completion return the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Slot write strobe |
| wr_grp_i | input | GW | Slot written |
| wr_chan_i | input | 5 | Channel number to store |
| wr_ie_i | input | 1 | Interrupt enable to store |
| rd_en_i | input | 1 | Result read strobe, clears done |
| rd_grp_i | input | GW | Slot read |
| rd_data_o | output | RES_W | Result of slot rd_grp_i |
| hw_mode_i | input | 1 | 1 = hardware triggering, 0 = software |
| hw_trig_i | input | 1 | Hardware trigger pulse |
| cont_i | input | 1 | Continuous conversion |
| long_mode_i | input | 3 | Sample-phase length code |
| clk_div_i | input | 2 | Converter clock divide code |
| conv_start_o | output | 1 | Start strobe to converter |
| conv_chan_o | output | 5 | Channel for the converter |
| conv_abort_o | output | 1 | Cancels the running conversion |
| conv_done_i | input | 1 | Converter finished |
| conv_data_i | input | RES_W | Converted sample |
| done_o | output | NG | Per-slot done flags |
| irq_o | output | 1 | Interrupt request |
| active_o | output | 1 | A conversion is in progress |
| act_grp_o | output | GW | Slot owning the converter |

## Verification
The hardest situation to reach is an abort that lands after the start strobe and before the converter answers. The stimulus waits until conv_start_o is observed, then writes the owning slot within the converter's latency window. It then confirms that the abort strobe fired, that no done bit appeared and that the earlier result survived. The timing sweep runs every long-sample code against every divide code. It compares the cycle on which the start strobe appears against the product computed in the bench.

// File: rtl/adc_grp_seq_pkg.sv
package adc_grp_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} seq_st_e;

  function automatic logic [4:0] smp_len(input logic [2:0] mode);
    case (mode)
      3'd0:    smp_len = 5'd24;
      3'd1:    smp_len = 5'd16;
      3'd2:    smp_len = 5'd10;
      3'd3:    smp_len = 5'd6;
      default: smp_len = 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/adc_clk_tick.sv
module adc_clk_tick #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((1 << div_i) - 1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_grp_regs.sv
module adc_grp_regs #(
  parameter int NG    = 4,
  parameter int CH_W  = 5,
  parameter int RES_W = 12,
  localparam int GW   = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [GW-1:0]              wr_grp_i,
  input  logic [CH_W-1:0]            wr_chan_i,
  input  logic                       wr_ie_i,
  input  logic                       rd_en_i,
  input  logic [GW-1:0]              rd_grp_i,
  input  logic                       cmp_i,
  input  logic [GW-1:0]              cmp_grp_i,
  input  logic [RES_W-1:0]           cmp_data_i,
  input  logic [GW-1:0]              act_grp_i,
  output logic [CH_W-1:0]            act_chan_o,
  output logic [RES_W-1:0]           rd_data_o,
  output logic [NG-1:0]              done_o,
  output logic                       irq_o
);
  logic [NG-1:0][CH_W-1:0]  chan_q;
  logic [NG-1:0][RES_W-1:0] res_q;
  logic [NG-1:0]            ie_q;
  logic [NG-1:0]            done_q;

  for (genvar g = 0; g < NG; g++) begin : g_slot
    logic sel_wr, sel_rd, sel_cmp;
    assign sel_wr  = wr_en_i && (wr_grp_i == GW'(g));
    assign sel_rd  = rd_en_i && (rd_grp_i == GW'(g));
    assign sel_cmp = cmp_i && (cmp_grp_i == GW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_q[g] <= '0;
        ie_q[g]   <= 1'b0;
        done_q[g] <= 1'b0;
        res_q[g]  <= '0;
      end else begin
        if (sel_wr) begin
          chan_q[g] <= wr_chan_i;
          ie_q[g]   <= wr_ie_i;
        end
        // completion beats a same-cycle read clear
        if (sel_cmp) begin
          done_q[g] <= 1'b1;
          res_q[g]  <= cmp_data_i;
        end else if (sel_rd) begin
          done_q[g] <= 1'b0;
        end
      end
    end
  end

  assign act_chan_o = chan_q[act_grp_i];
  assign rd_data_o  = res_q[rd_grp_i];
  assign done_o     = done_q;
  assign irq_o      = |(done_q & ie_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_grp_seq_pkg::*;
#(
  parameter int NG  = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [GW-1:0] wr_grp_i,
  input  logic          hw_mode_i,
  input  logic          hw_trig_i,
  input  logic          cont_i,
  input  logic [2:0]    long_mode_i,
  input  logic          tick_i,
  input  logic          conv_done_i,
  output logic          clear_o,
  output logic          run_o,
  output logic          start_o,
  output logic          abort_o,
  output logic          cmp_o,
  output logic          active_o,
  output logic [GW-1:0] grp_o
);
  seq_st_e       st_q;
  logic [GW-1:0] grp_q, ptr_q;
  logic [4:0]    smp_q, len;
  logic          start_q;
  logic          hit, sw_go, hw_go, last;

  assign len     = smp_len(long_mode_i);
  assign hit     = wr_en_i && (wr_grp_i == grp_q) && (st_q != ST_IDLE);
  assign sw_go   = !hw_mode_i && wr_en_i && (wr_grp_i == '0);
  assign hw_go   = hw_mode_i && hw_trig_i;
  assign last    = (smp_q == len - 5'd1);
  assign cmp_o   = (st_q == ST_CONV) && conv_done_i && !hit;
  assign abort_o = hit && (st_q == ST_CONV);
  assign run_o   = (st_q == ST_SAMPLE);
  assign clear_o = hit ? sw_go
                 : (st_q == ST_IDLE) ? (sw_go || hw_go)
                 : (cmp_o && cont_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      grp_q   <= '0;
      ptr_q   <= '0;
      smp_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (hit) begin
        smp_q <= '0;
        if (sw_go) begin
          st_q  <= ST_SAMPLE;
          grp_q <= '0;
        end else begin
          st_q  <= ST_IDLE;
        end
      end else begin
        case (st_q)
          ST_IDLE: begin
            smp_q <= '0;
            if (sw_go) begin
              st_q  <= ST_SAMPLE;
              grp_q <= '0;
            end else if (hw_go) begin
              st_q  <= ST_SAMPLE;
              grp_q <= ptr_q;
              ptr_q <= (ptr_q == GW'(NG - 1)) ? '0 : ptr_q + 1'b1;
            end
          end
          ST_SAMPLE: begin
            if (tick_i) begin
              if (last) begin
                st_q    <= ST_CONV;
                start_q <= 1'b1;
                smp_q   <= '0;
              end else begin
                smp_q <= smp_q + 5'd1;
              end
            end
          end
          ST_CONV: begin
            if (cmp_o) st_q <= cont_i ? ST_SAMPLE : ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign start_o  = start_q;
  assign active_o = (st_q != ST_IDLE);
  assign grp_o    = grp_q;
endmodule

// File: rtl/adc_grp_seq.sv
module adc_grp_seq #(
  parameter int NG    = 4,
  parameter int CH_W  = 5,
  parameter int RES_W = 12,
  parameter int DIV_W = 2,
  localparam int GW   = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [GW-1:0]    wr_grp_i,
  input  logic [CH_W-1:0]  wr_chan_i,
  input  logic             wr_ie_i,
  input  logic             rd_en_i,
  input  logic [GW-1:0]    rd_grp_i,
  output logic [RES_W-1:0] rd_data_o,
  input  logic             hw_mode_i,
  input  logic             hw_trig_i,
  input  logic             cont_i,
  input  logic [2:0]       long_mode_i,
  input  logic [DIV_W-1:0] clk_div_i,
  output logic             conv_start_o,
  output logic [CH_W-1:0]  conv_chan_o,
  output logic             conv_abort_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic [NG-1:0]    done_o,
  output logic             irq_o,
  output logic             active_o,
  output logic [GW-1:0]    act_grp_o
);
  logic clear, run, tick, cmp;

  adc_clk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .run_i   (run),
    .div_i   (clk_div_i),
    .tick_o  (tick)
  );

  adc_seq_ctrl #(.NG(NG)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_grp_i    (wr_grp_i),
    .hw_mode_i   (hw_mode_i),
    .hw_trig_i   (hw_trig_i),
    .cont_i      (cont_i),
    .long_mode_i (long_mode_i),
    .tick_i      (tick),
    .conv_done_i (conv_done_i),
    .clear_o     (clear),
    .run_o       (run),
    .start_o     (conv_start_o),
    .abort_o     (conv_abort_o),
    .cmp_o       (cmp),
    .active_o    (active_o),
    .grp_o       (act_grp_o)
  );

  adc_grp_regs #(.NG(NG), .CH_W(CH_W), .RES_W(RES_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_grp_i   (wr_grp_i),
    .wr_chan_i  (wr_chan_i),
    .wr_ie_i    (wr_ie_i),
    .rd_en_i    (rd_en_i),
    .rd_grp_i   (rd_grp_i),
    .cmp_i      (cmp),
    .cmp_grp_i  (act_grp_o),
    .cmp_data_i (conv_data_i),
    .act_grp_i  (act_grp_o),
    .act_chan_o (conv_chan_o),
    .rd_data_o  (rd_data_o),
    .done_o     (done_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/adc_grp_seq_chk.sv
module adc_grp_seq_chk #(
  parameter int NG    = 4,
  parameter int CH_W  = 5,
  parameter int RES_W = 12,
  parameter int DIV_W = 2,
  localparam int GW   = (NG > 1) ? $clog2(NG) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [GW-1:0]    wr_grp_i,
  input logic [CH_W-1:0]  wr_chan_i,
  input logic             wr_ie_i,
  input logic             rd_en_i,
  input logic [GW-1:0]    rd_grp_i,
  input logic [RES_W-1:0] rd_data_o,
  input logic             hw_mode_i,
  input logic             hw_trig_i,
  input logic             cont_i,
  input logic [2:0]       long_mode_i,
  input logic [DIV_W-1:0] clk_div_i,
  input logic             conv_start_o,
  input logic [CH_W-1:0]  conv_chan_o,
  input logic             conv_abort_o,
  input logic             conv_done_i,
  input logic [RES_W-1:0] conv_data_i,
  input logic [NG-1:0]    done_o,
  input logic             irq_o,
  input logic             active_o,
  input logic [GW-1:0]    act_grp_o
);
  // R10
  start_in_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> active_o);

  // R3
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R4
  done_from_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(done_o & ~$past(done_o))) |-> $past(conv_done_i));

  // R2
  sw_other_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_mode_i && wr_en_i && (wr_grp_i != '0) && !active_o) |=> !active_o);

  // R7
  hw_busy_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && active_o && hw_trig_i && !wr_en_i) |=> $stable(act_grp_o));

  // R8
  hw_abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && wr_en_i && active_o && (wr_grp_i == act_grp_o)) |=> !active_o);

  // R5
  irq_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o == '0) |-> !irq_o);
endmodule

bind adc_grp_seq adc_grp_seq_chk #(.NG(NG), .CH_W(CH_W), .RES_W(RES_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/adc_grp_seq_test.sv
`timescale 1ns/1ps
module adc_grp_seq_test;
  localparam int NG = 4, CH_W = 5, RES_W = 12, DIV_W = 2, GW = 2, LAT = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0, wr_ie = 0, rd_en = 0, hw_mode = 0, hw_trig = 0, cont = 0;
  logic [GW-1:0] wr_grp = '0, rd_grp = '0;
  logic [CH_W-1:0] wr_chan = '0;
  logic [2:0] long_mode = 3'd4;
  logic [DIV_W-1:0] clk_div = '0;
  logic conv_done = 0;
  logic [RES_W-1:0] conv_data = '0;
  logic [RES_W-1:0] rd_data;
  logic conv_start, conv_abort, irq, active;
  logic [CH_W-1:0] conv_chan;
  logic [NG-1:0] done;
  logic [GW-1:0] act_grp;

  int vectors = 0, fails = 0;
  int mdl_cnt = 0, mdl_seq = 0;
  logic [CH_W-1:0] mdl_ch = '0;
  logic [RES_W-1:0] mdl_last = '0;

  always #10 clk = ~clk;

  adc_grp_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_grp_i(wr_grp),
    .wr_chan_i(wr_chan), .wr_ie_i(wr_ie), .rd_en_i(rd_en), .rd_grp_i(rd_grp),
    .rd_data_o(rd_data), .hw_mode_i(hw_mode), .hw_trig_i(hw_trig), .cont_i(cont),
    .long_mode_i(long_mode), .clk_div_i(clk_div), .conv_start_o(conv_start),
    .conv_chan_o(conv_chan), .conv_abort_o(conv_abort), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .done_o(done), .irq_o(irq), .active_o(active),
    .act_grp_o(act_grp)
  );

  // behavioural converter: answers LAT cycles after the start strobe
  initial forever begin
    @(negedge clk);
    conv_done = 1'b0;
    if (conv_abort) mdl_cnt = 0;
    else if (conv_start) begin
      mdl_cnt = LAT;
      mdl_ch  = conv_chan;
    end else if (mdl_cnt > 0) begin
      mdl_cnt--;
      if (mdl_cnt == 0) begin
        mdl_last  = RES_W'((int'(mdl_ch) * 113 + mdl_seq * 7 + 5) % 4096);
        conv_data = mdl_last;
        conv_done = 1'b1;
        mdl_seq++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int m);
    case (m)
      0: return 24;
      1: return 16;
      2: return 10;
      3: return 6;
      default: return 4;
    endcase
  endfunction

  task automatic wr(input int g, input int ch, input bit ie);
    @(posedge clk); #1;
    wr_en = 1; wr_grp = GW'(g); wr_chan = CH_W'(ch); wr_ie = ie;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic trig();
    @(posedge clk); #1 hw_trig = 1;
    @(posedge clk); #1 hw_trig = 0;
  endtask

  task automatic rd_clear(input int g);
    @(posedge clk); #1 rd_en = 1; rd_grp = GW'(g);
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!conv_start && n < 1000) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic wait_done(input int g, output bit ok);
    ok = 0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      @(posedge clk); #1;
      if (done[g]) ok = 1;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    bit ok;
    logic [RES_W-1:0] saved;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    chk("R10 reset active", active, 0);
    chk("R4 reset done", done, 0);
    chk("R5 reset irq", irq, 0);

    // R3 sweep of every sample length and divide; R1 channel
    for (int m = 0; m < 5; m++) begin
      for (int d = 0; d < 4; d++) begin
        long_mode = 3'(m); clk_div = 2'(d);
        wr(0, m * 4 + d + 1, 0);
        chk("R10 active after start", active, 1);
        wait_start(n);
        chk("R3 start delay", n, exp_len(m) << d);
        chk("R1 channel", conv_chan, m * 4 + d + 1);
        wait_done(0, ok);
        chk("R4 done set", ok, 1);
        chk("R6 result", rd_data, mdl_last);
        rd_clear(0);
        chk("R6 done cleared", done[0], 0);
        chk("R10 idle after completion", active, 0);
      end
    end
    long_mode = 3'd5; clk_div = 0;

    // R2 writes to other slots in software mode
    for (int g = 1; g < NG; g++) begin
      wr(g, 3 + g, g == 1);
      n = 0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); #1;
        if (active || conv_start) n++;
      end
      chk("R2 no start from other slot", n, 0);
    end
    wr(0, 3, 0);
    wait_done(0, ok);
    rd_clear(0);

    // R7 round robin in hardware mode, R5 interrupt
    hw_mode = 1; long_mode = 3'd3;
    for (int i = 0; i < 6; i++) begin
      trig();
      chk("R7 slot order", act_grp, i % NG);
      trig();
      chk("R7 busy trigger ignored", act_grp, i % NG);
      wait_done(i % NG, ok);
      chk("R4 hw done", ok, 1);
      rd_grp = GW'(i % NG); #1;
      chk("R4 hw result", rd_data, mdl_last);
      chk("R4 one done bit", done, 1 << (i % NG));
      chk("R5 irq by enable", irq, (i % NG) == 1);
      rd_clear(i % NG);
      chk("R5 irq cleared", irq, 0);
    end

    // R8 abort after start strobe (slot 2)
    rd_grp = 2; #1 saved = rd_data;
    trig();
    chk("R7 slot 2", act_grp, 2);
    wait_start(n);
    @(posedge clk); #1;
    wr_en = 1; wr_grp = 2; wr_chan = 9; wr_ie = 0;
    #1 chk("R8 abort strobe", conv_abort, 1);
    @(posedge clk); #1 wr_en = 0;
    chk("R8 idle after abort", active, 0);
    repeat (10) @(posedge clk);
    #1 chk("R8 no done", done[2], 0);
    chk("R8 result kept", rd_data, saved);

    // R8 abort during sample (slot 3)
    trig();
    wr(3, 11, 0);
    chk("R8 sample abort idle", active, 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (conv_start) n++;
    end
    chk("R8 no start after abort", n, 0);

    // R9 rewrite another slot while slot 0 runs
    trig();
    chk("R7 wrap to slot 0", act_grp, 0);
    wr(1, 20, 1);
    chk("R9 still active", active, 1);
    wait_done(0, ok);
    chk("R9 completes", ok, 1);
    chk("R9 channel kept", mdl_ch, 3);
    rd_clear(0);

    // R8 software restart of slot 0
    hw_mode = 0; long_mode = 3'd4;
    wr(0, 5, 0);
    @(posedge clk); #1;
    wr(0, 6, 0);
    chk("R8 restart active", active, 1);
    wait_start(n);
    chk("R8 restart delay", n, 4);
    chk("R8 restart channel", conv_chan, 6);
    wait_done(0, ok);
    rd_clear(0);

    // R11 continuous
    cont = 1;
    wr(0, 7, 0);
    wait_done(0, ok);
    chk("R11 first done", ok, 1);
    chk("R11 rearmed", active, 1);
    rd_clear(0);
    wait_done(0, ok);
    chk("R11 second done", ok, 1);
    chk("R11 result", rd_data, mdl_last);
    rd_clear(0);
    cont = 0;
    wait_done(0, ok);
    repeat (2) @(posedge clk);
    #1 chk("R11 stops", active, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule